// File: doc/BRIEF.md
# Command-Line Completion Signal Unit

This block reports the end of a storage command in-band, over the single open-drain command line shared by a host and a storage device, so no extra interrupt pin is needed. It holds two cooperating state machines that see the same sampled line level. The device half arms once the response to a multi-block data-transfer command has gone out and interrupts are enabled. It then waits for the command layer to report the storage command finished, and answers by pulling the idle line low for exactly one bus cycle.

The host half arms when it has received that same response. It reports completion when it samples a single low cycle on the line while armed. Before it issues a new command, the host can withdraw a completion it no longer wants. It does this by pulling the line low for four cycles and then releasing it for one. The device recognises that run of zeros followed by a one, drops its pending completion and never drives, so the two sides never fight over the line.

A reset command on either side returns that side to idle at once. Command framing and CRC belong to neighbouring logic. The top has one `line_i` input carrying the resolved line level, computed outside as the wired-AND of every driver.

Top module: `line_done_notify`

States: the device runs DEV_IDLE, DEV_ARMED, DEV_PEND and DEV_SIGNAL. Its transitions are:
- arm: IDLE to ARMED.
- fire: ARMED or PEND to SIGNAL.
- hold: ARMED to PEND.
- disable or mask: ARMED or PEND to IDLE.
- finish: SIGNAL to IDLE.

The host runs HOST_IDLE, HOST_ARMED, HOST_CANCEL and HOST_RELEASE. Its transitions are:
- arm: IDLE to ARMED.
- detect: ARMED to IDLE.
- cancel: ARMED to CANCEL.
- release: CANCEL to RELEASE after RUN_LEN drive cycles.
- finish: RELEASE to IDLE.

A reset command takes any state to IDLE.

## Requirements
- R1: After reset every output is low and both sides are idle and disarmed.
- R2: The device arms on the cycle after `dev_resp_done_i` only when `dev_irq_dis_i` is 0. With it at 1 the device stays disarmed and never drives.
- R3: If armed, with the line high and no zero run under way, `dev_ata_done_i` makes the device drive low for exactly one cycle, starting the next cycle. `dev_sig_sent_o` is high in that same cycle, and the device is idle afterwards.
- R4: A finish report that arrives while the line is low is held (still armed). The device then fires once the line has been sampled high with its zero counter cleared.
- R5: While armed or holding, a run of at least four low samples followed by a high sample disarms the device without driving. `dev_dis_seen_o` is high in the cycle the line returns high.
- R6: A run of one to three low samples followed by a high sample leaves the device armed.
- R7: Raising `dev_irq_dis_i` while armed disarms the device without driving.
- R8: `dev_reset_cmd_i` returns the device to idle from any state, including the held state, and no drive follows.
- R9: The host arms on the cycle after `host_resp_done_i` when `host_irq_dis_i` is 0. While armed, a low line raises `host_done_o` in that cycle and disarms the host, so a device drive is seen in the cycle it occurs.
- R10: A low line while the host is idle produces no `host_done_o`.
- R11: `host_cancel_req_i` while the host is armed (line high) makes the host drive low for four consecutive cycles from the next cycle. One released cycle with `host_cancel_done_o` high follows, then idle. The host's own low drive is never reported as completion.
- R12: `host_cancel_req_i` while the host is idle is ignored, and the host does not drive.
- R13: `host_reset_cmd_i` returns the host to idle, and cuts short a disable pattern already being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Resolved level of the shared command line (1 = released) |
| dev_resp_done_i | input | 1 | Strobe: device finished sending the multi-block command response |
| dev_ata_done_i | input | 1 | Strobe: device command layer reports the storage command finished |
| dev_irq_dis_i | input | 1 | Device-side interrupt disable (1 = completion signalling off) |
| dev_reset_cmd_i | input | 1 | Strobe: device decoded a reset command |
| dev_drive_low_o | output | 1 | Device pulls the line low |
| dev_armed_o | output | 1 | Device waiting to signal completion |
| dev_sig_sent_o | output | 1 | Device is driving its completion zero this cycle |
| dev_dis_seen_o | output | 1 | Device recognised the disable pattern this cycle |
| host_resp_done_i | input | 1 | Strobe: host received the multi-block command response |
| host_irq_dis_i | input | 1 | Host-side interrupt disable (1 = do not wait for completion) |
| host_cancel_req_i | input | 1 | Strobe: host wants to withdraw a pending completion |
| host_reset_cmd_i | input | 1 | Strobe: host is issuing a reset command |
| host_drive_low_o | output | 1 | Host pulls the line low (disable pattern) |
| host_armed_o | output | 1 | Host waiting for a completion zero |
| host_done_o | output | 1 | Completion zero detected this cycle |
| host_cancel_done_o | output | 1 | Host is in the released cycle that ends the disable pattern |

## Verification
The assertions assume three things about the inputs. Every input strobe lasts one cycle. `line_i` is the wired-AND of both drive outputs and any outside driver. Reset commands are applied as ordinary synchronous strobes. The bench keeps to this by computing the line itself from both drive outputs and an extra low-driver of its own, and by raising each strobe for exactly one cycle after a rising edge. It uses that extra driver to create short runs, exact four-zero runs, longer runs and zeros that coincide with a finish report. A behavioural model is compared against every output on every clock.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    typedef enum logic [1:0] {
        DEV_IDLE   = 2'd0,
        DEV_ARMED  = 2'd1,
        DEV_PEND   = 2'd2,
        DEV_SIGNAL = 2'd3
    } dev_state_e;

    typedef enum logic [1:0] {
        HOST_IDLE    = 2'd0,
        HOST_ARMED   = 2'd1,
        HOST_CANCEL  = 2'd2,
        HOST_RELEASE = 2'd3
    } host_state_e;

endpackage

// File: rtl/lcs_zero_run.sv
// Counts consecutive low samples of the line while enabled (saturating),
// and flags a run of at least RUN_LEN zeros closed by a high sample.
module lcs_zero_run #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic line_i,
    output logic hit_o,
    output logic quiet_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || line_i) begin
            cnt_q <= '0;
        end else if (cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit_o   = en_i && line_i && (cnt_q == FULL);
    assign quiet_o = (cnt_q == '0);
endmodule

// File: rtl/lcs_dev_fsm.sv
// Device side: arm after the multi-block response, drive one zero on finish.
module lcs_dev_fsm
    import lcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic resp_done_i,
    input  logic ata_done_i,
    input  logic irq_dis_i,
    input  logic reset_cmd_i,
    input  logic line_i,
    input  logic run_hit_i,
    input  logic run_quiet_i,
    output logic drive_low_o,
    output logic armed_o,
    output logic sig_sent_o,
    output logic dis_seen_o
);
    dev_state_e state_q, state_d;
    logic       line_free;

    assign line_free = line_i && run_quiet_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DEV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (reset_cmd_i) begin
            state_d = DEV_IDLE;
        end else begin
            unique case (state_q)
                DEV_IDLE: begin
                    if (resp_done_i && !irq_dis_i) state_d = DEV_ARMED;
                end
                DEV_ARMED: begin
                    if (run_hit_i)       state_d = DEV_IDLE;
                    else if (irq_dis_i)  state_d = DEV_IDLE;
                    else if (ata_done_i) state_d = line_free ? DEV_SIGNAL : DEV_PEND;
                end
                DEV_PEND: begin
                    if (run_hit_i)      state_d = DEV_IDLE;
                    else if (irq_dis_i) state_d = DEV_IDLE;
                    else if (line_free) state_d = DEV_SIGNAL;
                end
                DEV_SIGNAL: state_d = DEV_IDLE;
            endcase
        end
    end

    always_comb begin
        drive_low_o = 1'b0;
        armed_o     = 1'b0;
        sig_sent_o  = 1'b0;
        unique case (state_q)
            DEV_IDLE:   ;
            DEV_ARMED:  armed_o = 1'b1;
            DEV_PEND:   armed_o = 1'b1;
            DEV_SIGNAL: begin
                drive_low_o = 1'b1;
                sig_sent_o  = 1'b1;
            end
        endcase
        dis_seen_o = armed_o && run_hit_i;
    end
endmodule

// File: rtl/lcs_host_fsm.sv
// Host side: detect a completion zero or send the zeros-then-one disable.
module lcs_host_fsm
    import lcs_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic resp_done_i,
    input  logic irq_dis_i,
    input  logic cancel_req_i,
    input  logic reset_cmd_i,
    input  logic line_i,
    output logic drive_low_o,
    output logic armed_o,
    output logic done_o,
    output logic cancel_done_o
);
    localparam int CW = $clog2(RUN_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    host_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HOST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (state_q != HOST_CANCEL) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        state_d = state_q;
        if (reset_cmd_i) begin
            state_d = HOST_IDLE;
        end else begin
            unique case (state_q)
                HOST_IDLE: begin
                    if (resp_done_i && !irq_dis_i) state_d = HOST_ARMED;
                end
                HOST_ARMED: begin
                    if (!line_i)           state_d = HOST_IDLE;
                    else if (cancel_req_i) state_d = HOST_CANCEL;
                end
                HOST_CANCEL: begin
                    if (cnt_q == LAST) state_d = HOST_RELEASE;
                end
                HOST_RELEASE: state_d = HOST_IDLE;
            endcase
        end
    end

    always_comb begin
        drive_low_o   = 1'b0;
        armed_o       = 1'b0;
        cancel_done_o = 1'b0;
        unique case (state_q)
            HOST_IDLE:    ;
            HOST_ARMED:   armed_o = 1'b1;
            HOST_CANCEL:  drive_low_o = 1'b1;
            HOST_RELEASE: cancel_done_o = 1'b1;
        endcase
        done_o = armed_o && !line_i;
    end
endmodule

// File: rtl/line_done_notify.sv
module line_done_notify #(
    parameter int RUN_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic dev_resp_done_i,
    input  logic dev_ata_done_i,
    input  logic dev_irq_dis_i,
    input  logic dev_reset_cmd_i,
    output logic dev_drive_low_o,
    output logic dev_armed_o,
    output logic dev_sig_sent_o,
    output logic dev_dis_seen_o,
    input  logic host_resp_done_i,
    input  logic host_irq_dis_i,
    input  logic host_cancel_req_i,
    input  logic host_reset_cmd_i,
    output logic host_drive_low_o,
    output logic host_armed_o,
    output logic host_done_o,
    output logic host_cancel_done_o
);
    logic run_hit;
    logic run_quiet;
    logic dev_armed;

    lcs_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dev_armed),
        .line_i  (line_i),
        .hit_o   (run_hit),
        .quiet_o (run_quiet)
    );

    lcs_dev_fsm u_dev (
        .clk         (clk),
        .rst_n       (rst_n),
        .resp_done_i (dev_resp_done_i),
        .ata_done_i  (dev_ata_done_i),
        .irq_dis_i   (dev_irq_dis_i),
        .reset_cmd_i (dev_reset_cmd_i),
        .line_i      (line_i),
        .run_hit_i   (run_hit),
        .run_quiet_i (run_quiet),
        .drive_low_o (dev_drive_low_o),
        .armed_o     (dev_armed),
        .sig_sent_o  (dev_sig_sent_o),
        .dis_seen_o  (dev_dis_seen_o)
    );

    assign dev_armed_o = dev_armed;

    lcs_host_fsm #(.RUN_LEN(RUN_LEN)) u_host (
        .clk           (clk),
        .rst_n         (rst_n),
        .resp_done_i   (host_resp_done_i),
        .irq_dis_i     (host_irq_dis_i),
        .cancel_req_i  (host_cancel_req_i),
        .reset_cmd_i   (host_reset_cmd_i),
        .line_i        (line_i),
        .drive_low_o   (host_drive_low_o),
        .armed_o       (host_armed_o),
        .done_o        (host_done_o),
        .cancel_done_o (host_cancel_done_o)
    );
endmodule

// File: rtl/line_done_notify_chk.sv
module line_done_notify_chk #(
    parameter int RUN_LEN = 4
) (
    input logic clk,
    input logic rst_n,
    input logic line_i,
    input logic dev_resp_done_i,
    input logic dev_irq_dis_i,
    input logic dev_reset_cmd_i,
    input logic dev_drive_low_o,
    input logic dev_armed_o,
    input logic dev_dis_seen_o,
    input logic host_reset_cmd_i,
    input logic host_drive_low_o,
    input logic host_done_o,
    input logic host_armed_o,
    input logic host_cancel_done_o
);
    int unsigned drv_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                drv_run_q <= 0;
        else if (host_drive_low_o) drv_run_q <= drv_run_q + 1;
        else                       drv_run_q <= 0;
    end

    assert_arm_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_armed_o) |-> $past(dev_resp_done_i && !dev_irq_dis_i));

    assert_single_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dev_drive_low_o |=> !dev_drive_low_o);

    assert_drive_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_drive_low_o) |-> $past(dev_armed_o));

    assert_disable_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dis_seen_o |=> (!dev_armed_o && !dev_drive_low_o));

    assert_dev_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_cmd_i |=> (!dev_armed_o && !dev_drive_low_o));

    assert_done_on_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done_o |-> !line_i);

    assert_no_self_detect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drive_low_o && host_done_o));

    assert_pattern_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_drive_low_o) && !$past(host_reset_cmd_i)) |-> (drv_run_q == RUN_LEN));

    assert_release_after_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_drive_low_o) && !$past(host_reset_cmd_i)) |-> host_cancel_done_o);

    assert_host_reset_R13: assert property (@(posedge clk) disable iff (!rst_n)
        host_reset_cmd_i |=> (!host_armed_o && !host_drive_low_o));
endmodule

bind line_done_notify line_done_notify_chk #(.RUN_LEN(RUN_LEN)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .line_i             (line_i),
    .dev_resp_done_i    (dev_resp_done_i),
    .dev_irq_dis_i      (dev_irq_dis_i),
    .dev_reset_cmd_i    (dev_reset_cmd_i),
    .dev_drive_low_o    (dev_drive_low_o),
    .dev_armed_o        (dev_armed_o),
    .dev_dis_seen_o     (dev_dis_seen_o),
    .host_reset_cmd_i   (host_reset_cmd_i),
    .host_drive_low_o   (host_drive_low_o),
    .host_done_o        (host_done_o),
    .host_armed_o       (host_armed_o),
    .host_cancel_done_o (host_cancel_done_o)
);

// File: tb/line_done_notify_tb.sv
`timescale 1ns/1ps
module line_done_notify_tb;
    localparam int RUN_LEN = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic dev_resp = 0, dev_done = 0, dev_dis = 0, dev_rst = 0;
    logic host_resp = 0, host_dis = 0, host_cancel = 0, host_rst = 0;
    logic ext_low = 0;
    logic dev_drive, dev_armed, dev_sig, dev_dseen;
    logic host_drive, host_armed, host_hdone, host_cdone;
    logic line;

    assign line = !(dev_drive || host_drive || ext_low);

    line_done_notify #(.RUN_LEN(RUN_LEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line),
        .dev_resp_done_i(dev_resp), .dev_ata_done_i(dev_done),
        .dev_irq_dis_i(dev_dis), .dev_reset_cmd_i(dev_rst),
        .dev_drive_low_o(dev_drive), .dev_armed_o(dev_armed),
        .dev_sig_sent_o(dev_sig), .dev_dis_seen_o(dev_dseen),
        .host_resp_done_i(host_resp), .host_irq_dis_i(host_dis),
        .host_cancel_req_i(host_cancel), .host_reset_cmd_i(host_rst),
        .host_drive_low_o(host_drive), .host_armed_o(host_armed),
        .host_done_o(host_hdone), .host_cancel_done_o(host_cdone)
    );

    int checks = 0, fails = 0;
    int n_fire = 0, n_hdone = 0, n_dis = 0, n_cdone = 0, n_hdrv = 0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference: 0 idle, 1 armed, 2 holding, 3 signalling (device);
    // 0 idle, 1 armed, 2 sending zeros, 3 released one (host).
    int m_dst = 0, m_dz = 0, m_hst = 0, m_hc = 0;

    function automatic bit m_line();
        return !((m_dst == 3) || (m_hst == 2) || ext_low);
    endfunction

    function automatic bit m_hit();
        return ((m_dst == 1) || (m_dst == 2)) && m_line() && (m_dz >= RUN_LEN);
    endfunction

    always @(posedge clk) begin
        bit ln, hit;
        int nd, nh;
        ln  = m_line();
        hit = m_hit();
        if (!rst_n) begin
            m_dst = 0; m_dz = 0; m_hst = 0; m_hc = 0;
        end else begin
            nd = m_dst;
            if (dev_rst) nd = 0;
            else if (m_dst == 0) begin
                if (dev_resp && !dev_dis) nd = 1;
            end else if (m_dst == 3) nd = 0;
            else if (hit || dev_dis) nd = 0;
            else if ((m_dst == 2 || dev_done) && ln && m_dz == 0) nd = 3;
            else if (dev_done) nd = 2;
            if ((m_dst == 1 || m_dst == 2) && !ln) m_dz = (m_dz < RUN_LEN) ? m_dz + 1 : RUN_LEN;
            else m_dz = 0;
            m_dst = nd;

            nh = m_hst;
            if (host_rst) nh = 0;
            else if (m_hst == 0) begin
                if (host_resp && !host_dis) nh = 1;
            end else if (m_hst == 1) begin
                if (!ln) nh = 0;
                else if (host_cancel) nh = 2;
            end else if (m_hst == 2) begin
                if (m_hc == RUN_LEN - 1) nh = 3;
            end else nh = 0;
            m_hc  = (m_hst == 2) ? m_hc + 1 : 0;
            if (nh != 2) m_hc = 0;
            m_hst = nh;
        end
    end

    always @(negedge clk) begin
        check("R3 dev_drive_low", int'(dev_drive), int'(m_dst == 3));
        check("R2 dev_armed", int'(dev_armed), int'(m_dst == 1 || m_dst == 2));
        check("R3 dev_sig_sent", int'(dev_sig), int'(m_dst == 3));
        check("R5 dev_dis_seen", int'(dev_dseen), int'(m_hit()));
        check("R11 host_drive_low", int'(host_drive), int'(m_hst == 2));
        check("R9 host_armed", int'(host_armed), int'(m_hst == 1));
        check("R9 host_done", int'(host_hdone), int'(m_hst == 1 && !m_line()));
        check("R11 host_cancel_done", int'(host_cdone), int'(m_hst == 3));
        n_fire  += int'(dev_sig);
        n_hdone += int'(host_hdone);
        n_dis   += int'(dev_dseen);
        n_cdone += int'(host_cdone);
        n_hdrv  += int'(host_drive);
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic arm_dev();
        dev_resp = 1; tick(1); dev_resp = 0;
    endtask

    task automatic arm_host();
        host_resp = 1; tick(1); host_resp = 0;
    endtask

    task automatic finish_dev();
        dev_done = 1; tick(1); dev_done = 0;
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        fails++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int f0, h0, d0, c0, v0;
        tick(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset dev_armed", int'(dev_armed), 0);
        check("R1 reset host_armed", int'(host_armed), 0);
        check("R1 reset drives", int'(dev_drive || host_drive), 0);
        tick(1);

        // R2 R3 R9: normal completion seen by host in the drive cycle
        dev_resp = 1; host_resp = 1; tick(1); dev_resp = 0; host_resp = 0;
        tick(1);
        check("R2 armed after response", int'(dev_armed), 1);
        check("R9 host armed after response", int'(host_armed), 1);
        f0 = n_fire; h0 = n_hdone;
        finish_dev(); tick(3);
        check("R3 one completion zero", n_fire - f0, 1);
        check("R9 host saw completion", n_hdone - h0, 1);
        check("R3 device idle after", int'(dev_armed), 0);

        // R2: masked interrupts do not arm
        dev_dis = 1; arm_dev(); tick(1);
        check("R2 masked no arm", int'(dev_armed), 0);
        f0 = n_fire; finish_dev(); tick(3);
        check("R2 masked no drive", n_fire - f0, 0);
        dev_dis = 0;

        // R5 R11: host withdraws a pending completion
        arm_dev(); arm_host(); tick(1);
        f0 = n_fire; h0 = n_hdone; d0 = n_dis; c0 = n_cdone; v0 = n_hdrv;
        host_cancel = 1; tick(1); host_cancel = 0;
        tick(7);
        check("R5 disable recognised", n_dis - d0, 1);
        check("R5 device disarmed", int'(dev_armed), 0);
        check("R11 four zero cycles", n_hdrv - v0, RUN_LEN);
        check("R11 release cycle", n_cdone - c0, 1);
        check("R11 own zeros not completion", n_hdone - h0, 0);
        finish_dev(); tick(3);
        check("R5 no drive after disable", n_fire - f0, 0);

        // R6 then R3: short zero run keeps the device armed
        arm_dev(); tick(1);
        d0 = n_dis; f0 = n_fire;
        ext_low = 1; tick(3); ext_low = 0; tick(2);
        check("R6 short run keeps armed", int'(dev_armed), 1);
        check("R6 short run not a disable", n_dis - d0, 0);
        finish_dev(); tick(3);
        check("R3 fires after short run", n_fire - f0, 1);

        // R4: finish report during a low line is held
        arm_dev(); tick(1);
        f0 = n_fire;
        ext_low = 1; tick(1);
        finish_dev();
        ext_low = 0;
        @(negedge clk);
        check("R4 held while line was low", n_fire - f0, 0);
        check("R4 still armed", int'(dev_armed), 1);
        tick(5);
        check("R4 held completion delivered", n_fire - f0, 1);

        // R5: outside run of exactly four and of six zeros while holding
        arm_dev(); tick(1);
        d0 = n_dis; f0 = n_fire;
        ext_low = 1; tick(1); finish_dev(); tick(2); ext_low = 0; tick(3);
        check("R5 four-zero run disables holding device", n_dis - d0, 1);
        check("R5 no drive after four-zero run", n_fire - f0, 0);
        arm_dev(); tick(1);
        ext_low = 1; tick(6); ext_low = 0; tick(2);
        check("R5 long run disables", n_dis - d0, 2);

        // R7: masking while armed
        arm_dev(); tick(1);
        f0 = n_fire;
        dev_dis = 1; tick(2);
        check("R7 mask disarms", int'(dev_armed), 0);
        dev_dis = 0; finish_dev(); tick(3);
        check("R7 no drive after mask", n_fire - f0, 0);

        // R8: reset command while holding
        arm_dev(); tick(1);
        f0 = n_fire;
        ext_low = 1; finish_dev();
        dev_rst = 1; tick(1); dev_rst = 0;
        ext_low = 0; tick(4);
        check("R8 reset disarms", int'(dev_armed), 0);
        check("R8 no drive after reset", n_fire - f0, 0);

        // R13: reset command cuts a disable pattern short
        arm_host(); tick(1);
        v0 = n_hdrv; c0 = n_cdone;
        host_cancel = 1; tick(1); host_cancel = 0;
        tick(1);
        host_rst = 1; tick(1); host_rst = 0;
        tick(3);
        check("R13 pattern cut short", n_hdrv - v0, 2);
        check("R13 no release cycle", n_cdone - c0, 0);
        check("R13 host idle", int'(host_armed || host_drive), 0);

        // R10 R12: idle host ignores zeros and cancel requests
        h0 = n_hdone; v0 = n_hdrv;
        ext_low = 1; tick(1); ext_low = 0; tick(2);
        check("R10 idle host ignores zero", n_hdone - h0, 0);
        host_cancel = 1; tick(1); host_cancel = 0; tick(6);
        check("R12 idle cancel ignored", n_hdrv - v0, 0);

        // R9: masked host does not arm
        host_dis = 1; arm_host(); tick(1);
        check("R9 masked host no arm", int'(host_armed), 0);
        host_dis = 0;

        tick(2);
        summary();
    end
endmodule